// File: doc/BRIEF.md
# Shared Converter Access Arbiter

This block decides which of three controllers may use a single shared analog-to-digital converter. The three controllers are a low-power sequencer (index 0), a digital streaming engine (index 1) and a radio power-detect engine (index 2). Each one raises a request line and receives a one-hot grant. The owner keeps the converter until the converter signals that the conversion is done. The grant is never taken away in the middle of a conversion.

The arbitration policy and the per-requester priorities sit in configuration registers. Those registers load from plain input signals on a load strobe. Three policies are available:
- **Pinned**: only the requester with the highest configured priority can ever win.
- **Ranked**: the highest-priority active requester wins.
- **Rotating**: requesters are equal and ownership passes in index order after each conversion.

When a conversion finishes, every requester that was waiting also receives a result beat. A requester that lost arbitration gets that beat with its channel tag forced to all ones. All ones is above any legal channel index, so consumers discard the beat.

Top module: `cvt_arbiter`

## Requirements
- R1: After reset, no grant is asserted, no result is valid, the policy is ranked, and the priorities are 1 for index 0, 0 for index 1 and 2 for index 2. With all three requesting, index 2 wins first.
- R2: The policy field (2 bits: 0 pinned, 1 ranked, 2 rotating, 3 reserved) and the priority field (2 bits per requester, index 0 in the low bits) are captured only on a clock edge where the load strobe is high. Otherwise changes on those inputs have no effect.
- R3: The grant vector is always one-hot or all zero.
- R4: In the ranked, rotating and reserved policies, a request seen while no grant is held produces a grant at the next clock edge.
- R5: While a grant is held and done is low, the grant does not change, whatever the requests do.
- R6: In ranked policy the active requester with the numerically largest priority wins. Equal priorities are resolved toward the lower index (0, then 1, then 2).
- R7: In pinned policy only the requester with the largest configured priority (ties toward the lower index) can be granted. Requests from the others leave the converter idle.
- R8: In rotating policy the winner is the first active requester after the most recent owner in circular index order. The most recent owner is tracked in every policy.
- R9: A done pulse while no grant is held has no effect: no result becomes valid and no grant appears.
- R10: On the edge after done, the owner gets a valid result carrying the converter data and channel. Every other requester that was requesting gets a valid result whose channel tag is all ones (15 with the default width), which is above the highest legal channel 9.
- R11: The reserved policy value 3 behaves as ranked.
- R12: On the edge that ends a conversion, arbitration is rerun among the current requests. The next owner's grant is visible on the cycle after done, with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NREQ | Request line per controller |
| done_i | input | 1 | Converter finished the current conversion |
| cfg_load_i | input | 1 | Load strobe for the policy and priority registers |
| cfg_mode_i | input | 2 | Policy code to load |
| cfg_prio_i | input | NREQ*2 | Priorities to load, 2 bits per requester |
| cvt_data_i | input | DW | Converter result data |
| cvt_chan_i | input | CW | Converter channel of the result |
| grant_o | output | NREQ | One-hot grant |
| busy_o | output | 1 | A grant is held |
| owner_o | output | IW | Index of the current owner |
| rslt_valid_o | output | NREQ | Result beat per requester |
| rslt_data_o | output | DW | Result data shared by all beats |
| rslt_chan_o | output | NREQ*CW | Channel tag per requester; all ones marks a denied result |

## Verification
The bench builds the block with its defaults: three requesters, 12-bit data and ten legal channels. Ten legal channels gives a 4-bit tag, so the denied tag value 15 is clearly separate from the largest legal channel 9. With three requesters, both the circular wrap from index 2 back to 0 and three-way priority ties can be reached. The bench also covers a pinned winner that is not requesting, late high-priority arrivals during a held grant, and back-to-back handovers under a long done pulse.

// File: rtl/cva_pkg.sv
package cva_pkg;
  localparam int PRIO_W = 2;

  typedef enum logic [1:0] {
    MODE_PINNED = 2'd0,
    MODE_RANKED = 2'd1,
    MODE_ROTATE = 2'd2,
    MODE_RSVD   = 2'd3
  } arb_mode_e;
endpackage

// File: rtl/cva_prio_pick.sv
module cva_prio_pick import cva_pkg::*; #(
  parameter int NREQ = 3
) (
  input  logic [NREQ-1:0]        cand_i,
  input  logic [NREQ*PRIO_W-1:0] prio_i,
  output logic [NREQ-1:0]        win_o
);
  logic              found;
  logic [PRIO_W-1:0] best;

  // Strict compare keeps the lower index on equal priority.
  always_comb begin
    win_o = '0;
    found = 1'b0;
    best  = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (cand_i[i] && (!found || prio_i[i*PRIO_W +: PRIO_W] > best)) begin
        win_o    = '0;
        win_o[i] = 1'b1;
        found    = 1'b1;
        best     = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/cva_rr_pick.sv
module cva_rr_pick #(
  parameter int NREQ = 3,
  parameter int IW   = 2
) (
  input  logic [NREQ-1:0] req_i,
  input  logic [IW-1:0]   last_i,
  output logic [NREQ-1:0] win_o
);
  logic found;

  always_comb begin
    win_o = '0;
    found = 1'b0;
    for (int k = 1; k <= NREQ; k++) begin
      int idx;
      idx = (int'(last_i) + k) % NREQ;
      if (!found && req_i[idx]) begin
        win_o[idx] = 1'b1;
        found      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cva_result_tag.sv
module cva_result_tag #(
  parameter int NREQ = 3,
  parameter int DW   = 12,
  parameter int CW   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire_i,
  input  logic [NREQ-1:0]    req_i,
  input  logic [NREQ-1:0]    grant_i,
  input  logic [DW-1:0]      data_i,
  input  logic [CW-1:0]      chan_i,
  output logic [NREQ-1:0]    valid_o,
  output logic [DW-1:0]      data_o,
  output logic [NREQ*CW-1:0] chan_o
);
  localparam logic [CW-1:0] DENIED = '1;

  logic [NREQ-1:0]    valid_d;
  logic [DW-1:0]      data_d;
  logic [NREQ*CW-1:0] chan_d;

  always_comb begin
    valid_d = '0;
    data_d  = data_o;
    chan_d  = chan_o;
    if (fire_i) begin
      valid_d = grant_i | req_i;
      data_d  = data_i;
    end
  end

  for (genvar g = 0; g < NREQ; g++) begin : g_tag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chan_o[g*CW +: CW] <= '0;
      end else if (fire_i) begin
        chan_o[g*CW +: CW] <= grant_i[g] ? chan_i : DENIED;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= '0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_d;
      if (fire_i) data_o <= data_d;
    end
  end

  logic unused_chan;
  assign unused_chan = ^chan_d;
endmodule

// File: rtl/cvt_arbiter.sv
module cvt_arbiter import cva_pkg::*; #(
  parameter int NREQ  = 3,
  parameter int DW    = 12,
  parameter int NCHAN = 10,
  parameter int CW    = $clog2(NCHAN + 1),
  parameter int IW    = (NREQ > 1) ? $clog2(NREQ) : 1,
  parameter logic [NREQ*PRIO_W-1:0] PRIO_RST = 6'b10_00_01,
  parameter logic [1:0] MODE_RST = 2'd1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NREQ-1:0]          req_i,
  input  logic                     done_i,
  input  logic                     cfg_load_i,
  input  logic [1:0]               cfg_mode_i,
  input  logic [NREQ*PRIO_W-1:0]   cfg_prio_i,
  input  logic [DW-1:0]            cvt_data_i,
  input  logic [CW-1:0]            cvt_chan_i,
  output logic [NREQ-1:0]          grant_o,
  output logic                     busy_o,
  output logic [IW-1:0]            owner_o,
  output logic [NREQ-1:0]          rslt_valid_o,
  output logic [DW-1:0]            rslt_data_o,
  output logic [NREQ*CW-1:0]       rslt_chan_o
);
  function automatic logic [IW-1:0] oh2idx(input logic [NREQ-1:0] oh);
    logic [IW-1:0] r;
    r = '0;
    for (int i = 0; i < NREQ; i++) if (oh[i]) r = IW'(i);
    return r;
  endfunction

  arb_mode_e               mode_q, mode_d;
  logic [NREQ*PRIO_W-1:0]  prio_q, prio_d;
  logic [NREQ-1:0]         grant_q, grant_d;
  logic [IW-1:0]           last_q, last_d;
  logic [NREQ-1:0]         ranked_win, pinned_top, rotate_win, pick;
  logic                    rearb;
  logic                    busy;

  cva_prio_pick #(.NREQ(NREQ)) u_ranked (
    .cand_i(req_i), .prio_i(prio_q), .win_o(ranked_win));

  cva_prio_pick #(.NREQ(NREQ)) u_pinned (
    .cand_i({NREQ{1'b1}}), .prio_i(prio_q), .win_o(pinned_top));

  cva_rr_pick #(.NREQ(NREQ), .IW(IW)) u_rotate (
    .req_i(req_i), .last_i(last_q), .win_o(rotate_win));

  // Configuration next state
  always_comb begin
    mode_d = mode_q;
    prio_d = prio_q;
    if (cfg_load_i) begin
      mode_d = arb_mode_e'(cfg_mode_i);
      prio_d = cfg_prio_i;
    end
  end

  // Policy select and grant next state
  always_comb begin
    unique case (mode_q)
      MODE_PINNED: pick = pinned_top & req_i;
      MODE_ROTATE: pick = rotate_win;
      default:     pick = ranked_win;
    endcase
    busy    = |grant_q;
    rearb   = !busy || done_i;
    grant_d = rearb ? pick : grant_q;
    last_d  = last_q;
    if (rearb && |pick) last_d = oh2idx(pick);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= arb_mode_e'(MODE_RST);
      prio_q <= PRIO_RST;
    end else if (cfg_load_i) begin
      mode_q <= mode_d;
      prio_q <= prio_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      last_q  <= IW'(NREQ - 1);
    end else if (rearb) begin
      grant_q <= grant_d;
      last_q  <= last_d;
    end
  end

  cva_result_tag #(.NREQ(NREQ), .DW(DW), .CW(CW)) u_tag (
    .clk(clk), .rst_n(rst_n), .fire_i(done_i && busy),
    .req_i(req_i), .grant_i(grant_q),
    .data_i(cvt_data_i), .chan_i(cvt_chan_i),
    .valid_o(rslt_valid_o), .data_o(rslt_data_o), .chan_o(rslt_chan_o));

  assign grant_o = grant_q;
  assign busy_o  = busy;
  assign owner_o = oh2idx(grant_q);
endmodule

// File: rtl/cvt_arbiter_chk.sv
module cvt_arbiter_chk #(
  parameter int NREQ = 3,
  parameter int CW   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NREQ-1:0]    req_i,
  input logic               done_i,
  input logic [1:0]         mode_q,
  input logic [NREQ-1:0]    grant_o,
  input logic               busy_o,
  input logic [NREQ-1:0]    rslt_valid_o,
  input logic [NREQ*CW-1:0] rslt_chan_o
);
  p_grant_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  p_idle_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && (|req_i) && mode_q != 2'd0) |=> busy_o);

  p_hold_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_i) |=> $stable(grant_o));

  p_grant_from_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|grant_o) && !$stable(grant_o)) |-> (|(grant_o & $past(req_i))));

  p_idle_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |=> (rslt_valid_o == '0));

  for (genvar g = 0; g < NREQ; g++) begin : g_deny
    p_denied_tag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rslt_valid_o[g] && !$past(grant_o[g])) |-> (rslt_chan_o[g*CW +: CW] == '1));
  end
endmodule

bind cvt_arbiter cvt_arbiter_chk #(.NREQ(NREQ), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .done_i(done_i),
  .mode_q(mode_q), .grant_o(grant_o), .busy_o(busy_o),
  .rslt_valid_o(rslt_valid_o), .rslt_chan_o(rslt_chan_o));

// File: tb/cvt_arbiter_test.sv
module cvt_arbiter_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  req;
  logic        done;
  logic        cfg_load;
  logic [1:0]  cfg_mode;
  logic [5:0]  cfg_prio;
  logic [11:0] cvt_data;
  logic [3:0]  cvt_chan;
  logic [2:0]  grant;
  logic        busy;
  logic [1:0]  owner;
  logic [2:0]  rvalid;
  logic [11:0] rdata;
  logic [11:0] rchan;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cvt_arbiter uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .done_i(done),
    .cfg_load_i(cfg_load), .cfg_mode_i(cfg_mode), .cfg_prio_i(cfg_prio),
    .cvt_data_i(cvt_data), .cvt_chan_i(cvt_chan),
    .grant_o(grant), .busy_o(busy), .owner_o(owner),
    .rslt_valid_o(rvalid), .rslt_data_o(rdata), .rslt_chan_o(rchan));

  function automatic logic [5:0] pk(input logic [1:0] p0, input logic [1:0] p1,
                                    input logic [1:0] p2);
    return {p2, p1, p0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic load_cfg(input logic [1:0] m, input logic [5:0] p);
    cfg_mode = m; cfg_prio = p; cfg_load = 1'b1;
    step();
    cfg_load = 1'b0;
  endtask

  task automatic release_all();
    req = 3'b000; done = 1'b1;
    step();
    done = 1'b0;
    step();
  endtask

  task automatic t_defaults();
    req = 3'b111; step();
    chk("R1 default radio wins", grant, 3'b100);
    chk("R1 owner index", owner, 2);
    chk("R4 busy after idle request", busy, 1);
    release_all();
    req = 3'b011; step();
    chk("R1 low-power prio1 beats digital prio0", grant, 3'b001);
    release_all();
  endtask

  task automatic t_cfg_gate();
    cfg_mode = 2'd2; cfg_prio = pk(2, 0, 0); cfg_load = 1'b0;
    step();
    req = 3'b111; step();
    chk("R2 unloaded config ignored", grant, 3'b100);
    release_all();
    load_cfg(2'd1, pk(2, 0, 0));
    req = 3'b111; step();
    chk("R2 loaded priorities used", grant, 3'b001);
    release_all();
    load_cfg(2'd1, pk(1, 0, 2));
  endtask

  task automatic t_hold_result();
    req = 3'b010; step();
    chk("R4 digital granted", grant, 3'b010);
    req = 3'b110; step(); step();
    chk("R5 grant held against higher prio", grant, 3'b010);
    req = 3'b100; step();
    chk("R5 grant held after owner drops", grant, 3'b010);
    req = 3'b110;
    cvt_data = 12'hABC; cvt_chan = 4'd5; done = 1'b1;
    step();
    done = 1'b0; req = 3'b000;
    chk("R12 handover without gap", grant, 3'b100);
    chk("R10 owner and waiter valid", rvalid, 3'b110);
    chk("R10 shared data", rdata, 12'hABC);
    chk("R10 owner channel", rchan[7:4], 4'd5);
    chk("R10 denied tag", rchan[11:8], 4'hF);
    cvt_chan = 4'd3; done = 1'b1; step();
    done = 1'b0;
    chk("R10 owner only valid", rvalid, 3'b100);
    chk("R10 radio own channel", rchan[11:8], 4'd3);
    chk("R12 idle after last done", grant, 3'b000);
    step();
  endtask

  task automatic t_idle_done();
    req = 3'b000; done = 1'b1; cvt_chan = 4'd7; step();
    done = 1'b0;
    chk("R9 no result when idle", rvalid, 3'b000);
    chk("R9 no grant when idle", grant, 3'b000);
    step();
  endtask

  task automatic t_tie();
    load_cfg(2'd1, pk(1, 1, 1));
    req = 3'b110; step();
    chk("R6 tie to lower index", grant, 3'b010);
    release_all();
    req = 3'b111; step();
    chk("R6 three-way tie", grant, 3'b001);
    release_all();
  endtask

  task automatic t_pinned();
    load_cfg(2'd0, pk(0, 2, 1));
    req = 3'b101; step();
    chk("R7 others ignored", grant, 3'b000);
    step();
    chk("R7 still idle", grant, 3'b000);
    req = 3'b111; step();
    chk("R7 pinned winner", grant, 3'b010);
    release_all();
  endtask

  task automatic t_rotate();
    load_cfg(2'd2, pk(2, 2, 2));
    req = 3'b111; step();
    chk("R8 after last owner 1", grant, 3'b100);
    done = 1'b1; step();
    chk("R8 wrap to 0", grant, 3'b001);
    step();
    chk("R8 next 1", grant, 3'b010);
    chk("R3 one-hot", $countones(grant), 1);
    step();
    chk("R8 next 2", grant, 3'b100);
    req = 3'b000; step();
    done = 1'b0;
    chk("R8 release", grant, 3'b000);
    step();
  endtask

  task automatic t_rsvd();
    load_cfg(2'd3, pk(0, 1, 2));
    req = 3'b011; step();
    chk("R11 reserved acts ranked", grant, 3'b010);
    release_all();
  endtask

  initial begin
    rst_n = 1'b0; req = '0; done = 1'b0; cfg_load = 1'b0;
    cfg_mode = '0; cfg_prio = '0; cvt_data = '0; cvt_chan = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R1 reset grant", grant, 3'b000);
    chk("R1 reset valid", rvalid, 3'b000);
    t_defaults();
    t_cfg_gate();
    t_hold_result();
    t_idle_done();
    t_tie();
    t_pinned();
    t_rotate();
    t_rsvd();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule